// File: doc/BRIEF.md
# Pattern Lock and Bit Error Monitor

This block checks a received serial test stream against a locally regenerated copy of the transmitted pattern. The local copy is a 32-stage shift register. It is first filled directly from the incoming bits. It then runs on its own feedback and is compared bit by bit with the stream. Once the comparison has been clean long enough, the block declares lock. From then on it watches the error density and counts bit errors.

The pattern is chosen by the same settings that drive the transmit generator. These settings select one of three kinds of pattern:
- a pseudorandom sequence with programmable length and tap;
- a fixed QRSS-style sequence;
- a repeating word of programmable period.

A rising edge on the load input restarts acquisition. A single-cycle update pulse copies the running bit and error totals into held outputs and starts a new measurement interval.

Top module: `prbs_lock_monitor`

## Requirements
- R1: After reset, `out_of_sync` is 1, `err_present` is 0, and both held counts are 0.
- R2: Acquisition starts at reset and on a rising edge of `load_req`. A rising edge of `load_req` sets `out_of_sync` on the next cycle. With a clean stream, `out_of_sync` falls on the clock edge that accepts the 64th received bit after acquisition starts. The first 32 bits are shifted straight into the local register; the next 32 are compared.
- R3: A mismatch while the 32 compared bits are being checked abandons the attempt and discards that bit. With a clean stream afterwards, lock is reached on the 64th bit after the mismatching one.
- R4: With `cfg_prbs`=1 and `cfg_qrss`=0, the next local bit is the XOR of stage `cfg_len`+1 and stage `cfg_tap`+1, where stage 1 holds the newest bit. When stages 1 to 31 are all zero, the next bit is forced to 1. With `cfg_prbs`=0 and `cfg_qrss`=0, the pattern repeats with period `cfg_len`+1.
- R5: With `cfg_qrss`=1, the feedback is the XOR of stages 17 and 20, whatever the length and tap fields hold. The expected bit is forced to 1 whenever stages 1 to 14 are all zero.
- R6: While locked, `out_of_sync` rises on the edge of a compared bit that makes 6 errors among the last 64 compared bits. An error compared 64 bits earlier no longer counts.
- R7: Bit errors are counted only while locked. The error that causes loss of lock is counted.
- R8: Every received bit (`rx_en`=1) is counted, whether or not the block is locked.
- R9: On `pm_update`, the held counts take the totals accumulated before that cycle and the running totals restart. A bit received in the same cycle as the update counts toward the new interval.
- R10: `err_present` is 1 exactly when the running error total is nonzero.
- R11: Both running totals stop at 2^`CNT_W`-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | A received bit is valid this cycle |
| rx_bit | input | 1 | Received data bit |
| cfg_len | input | 5 | Pattern length minus one (stage index of the length tap) |
| cfg_tap | input | 5 | Second feedback tap minus one (pseudorandom mode) |
| cfg_prbs | input | 1 | 1 = pseudorandom, 0 = repeating word |
| cfg_qrss | input | 1 | Fixed QRSS-style sequence; overrides the other fields |
| load_req | input | 1 | Rising edge restarts acquisition |
| pm_update | input | 1 | Snapshot and restart the totals |
| out_of_sync | output | 1 | Not locked to the incoming stream |
| err_present | output | 1 | Running error total is nonzero |
| bit_count_q | output | CNT_W (32) | Held received-bit total |
| err_count_q | output | CNT_W (32) | Held bit-error total |

## Verification
If the local register holds a wrong state or takes a wrong tap, a clean stream never passes the 32-bit check. The port then shows `out_of_sync` stuck high well past bit 64 of a lock attempt. An off-by-one in the error history or its running sum shows up as a loss of lock one bit early or late around the 64-bit boundary. A wrong snapshot ordering shows up at the next update as a held count off by one. The sweeps cover every repeat period from 1 to 32 and several pseudorandom polynomials. They also pin lock timing, window edges and snapshot contents to the exact cycle.

// File: rtl/plm_pkg.sv
package plm_pkg;

    localparam int PAT_W      = 32;
    localparam int SEL_W      = $clog2(PAT_W);
    localparam int QRSS_TAP_A = 16;
    localparam int QRSS_TAP_B = 19;
    localparam int QRSS_RUN   = 14;
    localparam int N_LANES    = 2;
    localparam int LANE_BITS  = 0;
    localparam int LANE_ERRS  = 1;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } sync_state_t;

    typedef struct packed {
        logic [SEL_W-1:0] len_m1;
        logic [SEL_W-1:0] tap_m1;
        logic             prbs;
        logic             qrss;
    } pat_cfg_t;

    // next bit fed back into stage 1
    function automatic logic pat_feedback(logic [PAT_W-1:0] s, pat_cfg_t c);
        logic fb;
        if (c.qrss)
            fb = s[QRSS_TAP_A] ^ s[QRSS_TAP_B];
        else if (c.prbs)
            fb = s[c.len_m1] ^ s[c.tap_m1];
        else
            fb = s[c.len_m1];
        if ((c.qrss || c.prbs) && (s[PAT_W-2:0] == '0))
            fb = 1'b1;
        return fb;
    endfunction

    // bit expected on the line
    function automatic logic pat_emit(logic [PAT_W-1:0] s, pat_cfg_t c);
        logic b;
        b = pat_feedback(s, c);
        if (c.qrss && (s[QRSS_RUN-1:0] == '0))
            b = 1'b1;
        return b;
    endfunction

endpackage

// File: rtl/plm_ref_gen.sv
module plm_ref_gen
    import plm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     adv,
    input  logic     load_mode,
    input  logic     rx_bit,
    input  pat_cfg_t cfg,
    output logic     exp_bit
);

    logic [PAT_W-1:0] shreg_q;
    logic             fb;

    always_comb begin
        fb      = pat_feedback(shreg_q, cfg);
        exp_bit = pat_emit(shreg_q, cfg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
        end else if (adv) begin
            if (load_mode)
                shreg_q <= {shreg_q[PAT_W-2:0], rx_bit};
            else
                shreg_q <= {shreg_q[PAT_W-2:0], fb};
        end
    end

endmodule

// File: rtl/plm_err_window.sv
module plm_err_window #(
    parameter int WIN_LEN   = 64,
    parameter int ERR_LIMIT = 6,
    localparam int SUM_W    = $clog2(WIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push,
    input  logic             err_in,
    output logic             trip,
    output logic [SUM_W-1:0] sum
);

    logic [WIN_LEN-1:0] hist_q;
    logic [SUM_W-1:0]   sum_q;
    logic [SUM_W-1:0]   sum_nxt;

    always_comb begin
        sum_nxt = sum_q + SUM_W'(err_in) - SUM_W'(hist_q[WIN_LEN-1]);
        trip    = push && (sum_nxt >= SUM_W'(ERR_LIMIT));
        sum     = sum_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hist_q <= '0;
            sum_q  <= '0;
        end else if (push) begin
            hist_q <= {hist_q[WIN_LEN-2:0], err_in};
            sum_q  <= sum_nxt;
        end
    end

endmodule

// File: rtl/plm_sync_fsm.sv
module plm_sync_fsm
    import plm_pkg::*;
#(
    parameter int LOAD_BITS = 32,
    parameter int LOCK_RUN  = 32,
    localparam int PH_MAX   = (LOAD_BITS > LOCK_RUN) ? LOAD_BITS : LOCK_RUN,
    localparam int PH_W     = $clog2(PH_MAX + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_en,
    input  logic        load_rise,
    input  logic        mismatch,
    input  logic        win_trip,
    output sync_state_t state
);

    sync_state_t     st_q;
    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_LOAD;
            ph_q <= '0;
        end else if (load_rise) begin
            st_q <= ST_LOAD;
            ph_q <= '0;
        end else if (rx_en) begin
            case (st_q)
                ST_LOAD: begin
                    if (ph_q == PH_W'(LOAD_BITS - 1)) begin
                        st_q <= ST_VERIFY;
                        ph_q <= '0;
                    end else begin
                        ph_q <= ph_q + 1'b1;
                    end
                end
                ST_VERIFY: begin
                    if (mismatch) begin
                        st_q <= ST_LOAD;
                        ph_q <= '0;
                    end else if (ph_q == PH_W'(LOCK_RUN - 1)) begin
                        st_q <= ST_LOCKED;
                        ph_q <= '0;
                    end else begin
                        ph_q <= ph_q + 1'b1;
                    end
                end
                ST_LOCKED: begin
                    if (win_trip) begin
                        st_q <= ST_LOAD;
                        ph_q <= '0;
                    end
                end
                default: begin
                    st_q <= ST_LOAD;
                    ph_q <= '0;
                end
            endcase
        end
    end

    assign state = st_q;

endmodule

// File: rtl/plm_sat_lane.sv
module plm_sat_lane #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         snap,
    output logic [W-1:0] run,
    output logic [W-1:0] held
);

    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] run_q;
    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            held_q <= '0;
        end else if (snap) begin
            held_q <= run_q;
            run_q  <= W'(inc);
        end else if (inc && (run_q != TOP)) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign run  = run_q;
    assign held = held_q;

endmodule

// File: rtl/prbs_lock_monitor.sv
module prbs_lock_monitor
    import plm_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int WIN_LEN   = 64,
    parameter int ERR_LIMIT = 6,
    parameter int LOAD_BITS = 32,
    parameter int LOCK_RUN  = 32,
    localparam int SUM_W    = $clog2(WIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_en,
    input  logic             rx_bit,
    input  logic [SEL_W-1:0] cfg_len,
    input  logic [SEL_W-1:0] cfg_tap,
    input  logic             cfg_prbs,
    input  logic             cfg_qrss,
    input  logic             load_req,
    input  logic             pm_update,
    output logic             out_of_sync,
    output logic             err_present,
    output logic [CNT_W-1:0] bit_count_q,
    output logic [CNT_W-1:0] err_count_q
);

    pat_cfg_t         cfg;
    sync_state_t      state;
    logic             load_q;
    logic             load_rise;
    logic             exp_bit;
    logic             mismatch;
    logic             win_push;
    logic             win_clear;
    logic             win_trip;
    logic [SUM_W-1:0] win_sum;
    logic [N_LANES-1:0] lane_inc;
    logic [CNT_W-1:0] lane_run  [N_LANES];
    logic [CNT_W-1:0] lane_held [N_LANES];
    logic [CNT_W-1:0] bit_run;

    always_comb begin
        cfg.len_m1 = cfg_len;
        cfg.tap_m1 = cfg_tap;
        cfg.prbs   = cfg_prbs;
        cfg.qrss   = cfg_qrss;
    end

    always_ff @(posedge clk) begin
        if (rst) load_q <= 1'b0;
        else     load_q <= load_req;
    end

    assign load_rise = load_req && !load_q;
    assign mismatch  = rx_bit ^ exp_bit;
    assign win_push  = rx_en && (state == ST_LOCKED);
    assign win_clear = (state != ST_LOCKED);

    plm_ref_gen u_gen (
        .clk       (clk),
        .rst       (rst),
        .adv       (rx_en),
        .load_mode (state == ST_LOAD),
        .rx_bit    (rx_bit),
        .cfg       (cfg),
        .exp_bit   (exp_bit)
    );

    plm_sync_fsm #(
        .LOAD_BITS (LOAD_BITS),
        .LOCK_RUN  (LOCK_RUN)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .rx_en     (rx_en),
        .load_rise (load_rise),
        .mismatch  (mismatch),
        .win_trip  (win_trip),
        .state     (state)
    );

    plm_err_window #(
        .WIN_LEN   (WIN_LEN),
        .ERR_LIMIT (ERR_LIMIT)
    ) u_win (
        .clk    (clk),
        .rst    (rst),
        .clear  (win_clear),
        .push   (win_push),
        .err_in (mismatch),
        .trip   (win_trip),
        .sum    (win_sum)
    );

    assign lane_inc[LANE_BITS] = rx_en;
    assign lane_inc[LANE_ERRS] = win_push && mismatch;

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        plm_sat_lane #(.W(CNT_W)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .inc  (lane_inc[g]),
            .snap (pm_update),
            .run  (lane_run[g]),
            .held (lane_held[g])
        );
    end

    assign bit_run     = lane_run[LANE_BITS];
    assign out_of_sync = (state != ST_LOCKED);
    assign err_present = (lane_run[LANE_ERRS] != '0);
    assign bit_count_q = lane_held[LANE_BITS];
    assign err_count_q = lane_held[LANE_ERRS];

endmodule

module prbs_lock_monitor_chk #(
    parameter int CNT_W     = 32,
    parameter int SUM_W     = 7,
    parameter int ERR_LIMIT = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_en,
    input logic             load_req,
    input logic             pm_update,
    input logic             out_of_sync,
    input logic             err_present,
    input logic [CNT_W-1:0] bit_count_q,
    input logic [CNT_W-1:0] err_count_q,
    input logic [CNT_W-1:0] bit_run,
    input logic [SUM_W-1:0] win_sum
);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_of_sync && !err_present && bit_count_q == '0 && err_count_q == '0));

    a_r2_load_unlocks: assert property (@(posedge clk) disable iff (rst)
        $rose(load_req) |=> out_of_sync);

    a_r6_window_below_limit: assert property (@(posedge clk) disable iff (rst)
        !out_of_sync |-> (win_sum < SUM_W'(ERR_LIMIT)));

    a_r7_no_count_unlocked: assert property (@(posedge clk) disable iff (rst)
        (out_of_sync && !err_present && !pm_update) |=> !err_present);

    a_r8_bit_step: assert property (@(posedge clk) disable iff (rst)
        (rx_en && !pm_update && bit_run != '1) |=> (bit_run == $past(bit_run) + 1'b1));

    a_r9_held_stable: assert property (@(posedge clk) disable iff (rst)
        !pm_update |=> ($stable(bit_count_q) && $stable(err_count_q)));

    a_r10_clear_on_update: assert property (@(posedge clk) disable iff (rst)
        (pm_update && out_of_sync) |=> !err_present);

    a_r11_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (rx_en && !pm_update) |=> (bit_run != '0));

endmodule

bind prbs_lock_monitor prbs_lock_monitor_chk #(
    .CNT_W     (CNT_W),
    .SUM_W     (SUM_W),
    .ERR_LIMIT (ERR_LIMIT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_en       (rx_en),
    .load_req    (load_req),
    .pm_update   (pm_update),
    .out_of_sync (out_of_sync),
    .err_present (err_present),
    .bit_count_q (bit_count_q),
    .err_count_q (err_count_q),
    .bit_run     (bit_run),
    .win_sum     (win_sum)
);

// File: tb/test_prbs_lock_monitor.sv
`timescale 1ns/1ps
module test_prbs_lock_monitor;

    localparam int SMALL_W = 6;
    localparam longint SMALL_MAX = 63;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_en = 1'b0, rx_bit = 1'b0, load_req = 1'b0, pm_update = 1'b0;
    logic [4:0] cfg_len = 5'd14, cfg_tap = 5'd13;
    logic cfg_prbs = 1'b1, cfg_qrss = 1'b0;
    logic oos, errp, oos_s, errp_s;
    logic [31:0] bcq, ecq;
    logic [SMALL_W-1:0] bcq_s, ecq_s;

    int n_chk = 0;
    int n_bad = 0;
    longint cur_b = 0, cur_e = 0, lat_b = 0, lat_e = 0;
    logic [31:0] tx_s = 32'h1357_9BDF;
    logic rep_mode = 1'b0;
    logic [31:0] rep_word = 32'hB38F_0E5D;
    int rep_idx = 0;

    always #2.5 clk = ~clk;

    prbs_lock_monitor i_prbs_lock_monitor (
        .clk(clk), .rst(rst), .rx_en(rx_en), .rx_bit(rx_bit),
        .cfg_len(cfg_len), .cfg_tap(cfg_tap), .cfg_prbs(cfg_prbs), .cfg_qrss(cfg_qrss),
        .load_req(load_req), .pm_update(pm_update),
        .out_of_sync(oos), .err_present(errp), .bit_count_q(bcq), .err_count_q(ecq));

    prbs_lock_monitor #(.CNT_W(SMALL_W)) i_prbs_lock_monitor_sat (
        .clk(clk), .rst(rst), .rx_en(rx_en), .rx_bit(rx_bit),
        .cfg_len(cfg_len), .cfg_tap(cfg_tap), .cfg_prbs(cfg_prbs), .cfg_qrss(cfg_qrss),
        .load_req(load_req), .pm_update(pm_update),
        .out_of_sync(oos_s), .err_present(errp_s), .bit_count_q(bcq_s), .err_count_q(ecq_s));

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic longint sat(input longint v);
        return (v > SMALL_MAX) ? SMALL_MAX : v;
    endfunction

    // transmit-side model of the pattern
    task automatic tx_next(output logic b);
        logic f;
        if (rep_mode) begin
            b = rep_word[rep_idx];
            rep_idx = (rep_idx >= int'(cfg_len)) ? 0 : rep_idx + 1;
        end else begin
            if (cfg_qrss) f = tx_s[16] ^ tx_s[19];
            else          f = tx_s[cfg_len] ^ tx_s[cfg_tap];
            if (tx_s[30:0] == 31'd0) f = 1'b1;
            b = (cfg_qrss && tx_s[13:0] == 14'd0) ? 1'b1 : f;
            tx_s = {tx_s[30:0], f};
        end
    endtask

    task automatic step(input logic en, input logic b, input logic upd, input logic ld, input logic cnt_err);
        @(negedge clk);
        rx_en = en; rx_bit = b; pm_update = upd; load_req = ld;
        @(posedge clk);
        #1;
        rx_en = 1'b0; pm_update = 1'b0; load_req = 1'b0;
        if (upd) begin
            lat_b = cur_b; lat_e = cur_e;
            cur_b = longint'(en); cur_e = longint'(cnt_err);
        end else begin
            cur_b += longint'(en); cur_e += longint'(cnt_err);
        end
    endtask

    task automatic send(input logic err, input logic counted);
        logic b;
        tx_next(b);
        step(1'b1, b ^ err, 1'b0, 1'b0, counted);
    endtask

    task automatic restart();
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic update_and_check(input string tag);
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk({tag, " R9 held bits"}, longint'(bcq), lat_b);
        chk({tag, " R7 held errors"}, longint'(ecq), lat_e);
        chk({tag, " R11 saturated bits"}, longint'(bcq_s), sat(lat_b));
        chk({tag, " R11 saturated errors"}, longint'(ecq_s), sat(lat_e));
        chk({tag, " R10 cleared after update"}, longint'(errp), 0);
    endtask

    task automatic lock_run(input string tag);
        restart();
        chk({tag, " R2 unlocked after load"}, longint'(oos), 1);
        for (int i = 0; i < 63; i++) send(1'b0, 1'b0);
        chk({tag, " R2 still unlocked at bit 63"}, longint'(oos), 1);
        send(1'b0, 1'b0);
        chk({tag, " R2 locked at bit 64"}, longint'(oos), 0);
    endtask

    function automatic bit qrss_seed_ok(input logic [31:0] seed);
        logic [31:0] s;
        logic f;
        int late;
        s = seed;
        late = 0;
        for (int i = 0; i < 160; i++) begin
            f = s[16] ^ s[19];
            if (s[30:0] == 31'd0) f = 1'b1;
            if (s[13:0] == 14'd0) begin
                if (i < 64) return 1'b0;
                late++;
            end
            s = {s[30:0], f};
        end
        return late > 0;
    endfunction

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [4:0] plen [7];
        logic [4:0] ptap [7];
        logic [31:0] qseed;
        bit found;
        plen = '{5'd8, 5'd10, 5'd14, 5'd19, 5'd22, 5'd30, 5'd6};
        ptap = '{5'd4, 5'd8, 5'd13, 5'd2, 5'd17, 5'd27, 5'd5};

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        chk("R1 reset out_of_sync", longint'(oos), 1);
        chk("R1 reset err_present", longint'(errp), 0);
        chk("R1 reset held bits", longint'(bcq), 0);
        chk("R1 reset held errors", longint'(ecq), 0);

        // R4 pseudorandom polynomials
        for (int k = 0; k < 7; k++) begin
            cfg_len = plen[k]; cfg_tap = ptap[k]; cfg_prbs = 1'b1; cfg_qrss = 1'b0;
            tx_s = 32'h1357_9BDF ^ (32'h0101_0101 * k);
            update_and_check("R4 prbs pre");
            lock_run("R4 prbs");
            for (int i = 0; i < 40; i++) send(1'b0, 1'b0);
            chk("R4 prbs stays locked", longint'(oos), 0);
            chk("R4 prbs no errors", longint'(errp), 0);
        end

        // R4 all-zero start state is forced out
        cfg_len = 5'd14; cfg_tap = 5'd13; tx_s = 32'd0;
        lock_run("R4 zero seed");
        for (int i = 0; i < 40; i++) send(1'b0, 1'b0);
        chk("R4 zero seed stays locked", longint'(oos), 0);
        update_and_check("R8 after zero seed");

        // R2 load while locked
        restart();
        chk("R2 load drops lock", longint'(oos), 1);

        // R3 mismatch during verification
        tx_s = 32'h0BAD_F00D;
        restart();
        for (int i = 0; i < 42; i++) send(1'b0, 1'b0);
        send(1'b1, 1'b0);
        for (int i = 0; i < 63; i++) send(1'b0, 1'b0);
        chk("R3 unlocked 63 bits after mismatch", longint'(oos), 1);
        send(1'b0, 1'b0);
        chk("R3 locked 64 bits after mismatch", longint'(oos), 0);
        update_and_check("R3");

        // R6 window: sixth error 64 bits after the first
        lock_run("R6a");
        for (int i = 0; i < 5; i++) send(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) send(1'b1, 1'b1);
        chk("R6 five errors keep lock", longint'(oos), 0);
        chk("R10 error present", longint'(errp), 1);
        for (int i = 0; i < 59; i++) send(1'b0, 1'b0);
        send(1'b1, 1'b1);
        chk("R6 oldest error left window", longint'(oos), 0);
        update_and_check("R6a");

        // R6 window: sixth error 63 bits after the first
        lock_run("R6b");
        for (int i = 0; i < 5; i++) send(1'b0, 1'b0);
        for (int i = 0; i < 5; i++) send(1'b1, 1'b1);
        for (int i = 0; i < 58; i++) send(1'b0, 1'b0);
        chk("R6 before sixth error", longint'(oos), 0);
        send(1'b1, 1'b1);
        chk("R6 six errors in window", longint'(oos), 1);

        // R7 garbage while unlocked is not counted
        for (int i = 0; i < 20; i++) send(1'b1, 1'b0);
        chk("R7 unlocked garbage", longint'(errp), 1);
        update_and_check("R7");

        // R9 update coincident with a received bit
        for (int i = 0; i < 10; i++) send(1'b0, 1'b0);
        begin
            logic b;
            tx_next(b);
            step(1'b1, b, 1'b1, 1'b0, 1'b0);
        end
        chk("R9 coincident bit excluded", longint'(bcq), 10);
        update_and_check("R9 coincident");
        chk("R9 coincident bit in new interval", longint'(bcq), 1);

        // R4 repeating word, every period 1..32
        rep_mode = 1'b1; cfg_prbs = 1'b0;
        for (int n = 1; n <= 32; n++) begin
            cfg_len = 5'(n - 1); cfg_tap = 5'd0; rep_idx = 0;
            update_and_check("R4 rep pre");
            lock_run("R4 rep");
            for (int i = 0; i < 20; i++) send(1'b0, 1'b0);
            send(1'b1, 1'b1);
            chk("R10 rep error present", longint'(errp), 1);
            for (int i = 0; i < 10; i++) send(1'b0, 1'b0);
            chk("R4 rep stays locked", longint'(oos), 0);
            update_and_check("R4 rep");
        end
        rep_mode = 1'b0;

        // R5 fixed sequence with forced ones after lock
        found = 1'b0;
        qseed = 32'd0;
        for (int k = 1; k < 30000 && !found; k++) begin
            if (qrss_seed_ok(32'h9E37_79B9 * k)) begin
                found = 1'b1;
                qseed = 32'h9E37_79B9 * k;
            end
        end
        chk("R5 seed search", longint'(found), 1);
        cfg_qrss = 1'b1; cfg_prbs = 1'b1; cfg_len = 5'd4; cfg_tap = 5'd1;
        tx_s = qseed;
        update_and_check("R5 pre");
        lock_run("R5");
        for (int i = 0; i < 96; i++) send(1'b0, 1'b0);
        chk("R5 locked through forced ones", longint'(oos), 0);
        chk("R5 no errors", longint'(errp), 0);
        update_and_check("R5");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule